// File: doc/BRIEF.md
# Stereo Disparity Row-Histogram Obstacle Detector

This block takes the per-pixel output of a stereo matcher as a stream of (image row, disparity) pairs and builds, for every frame, a two-dimensional histogram. The histogram has one row per image row and one column per disparity value. Each valid pair adds one to its cell through a read, increment and write-back cycle on an inferred block RAM. Two histogram RAMs take turns. A frame-start pulse hands the RAM that was just filled to a scanner, and the other RAM, which is already clear, starts collecting the new frame.

The scanner walks every cell of the closed frame once, in row-major order, and writes zero behind itself so that the RAM is empty when its next turn comes. Columns of small disparity (far away) are treated as background and skipped. Each remaining cell is binarized against a threshold. The cells that pass are counted per disparity column, which is a Hough vote restricted to vertical lines. A column whose vote count exceeds a second threshold marks an obstacle. At the end of the scan the block reports the nearest obstacle (the largest such disparity) and emits a one-cycle done pulse.

Top module: `vdo_detector`

## Requirements
- R1: Each cycle with `pix_valid` high and an in-range pair adds exactly one to the cell at (`pix_row`, `pix_disp`), including back-to-back pairs that hit the same cell on consecutive cycles.
- R2: A pair with `pix_disp` of NDISP or more (default 40) changes no cell.
- R3: A cell holds at 2^CELL_W-1 (default 255) instead of wrapping when more pairs arrive.
- R4: A `frame_start` accepted while the scanner is idle closes the current frame and starts the scan of that frame, while new pairs go to the other histogram. The scan clears every cell it reads, so each frame begins from an empty histogram. A `frame_start` that arrives while a scan is running is ignored.
- R5: Cells in disparity columns below BG_DISP (default 10) never contribute to detection, and column BG_DISP itself does.
- R6: A cell passes binarization only when its count is strictly greater than `bin_thresh`.
- R7: An obstacle is found at a disparity when the number of passing cells in its column is strictly greater than `hough_thresh`.
- R8: After a scan, `obst_valid` is 1 and `obst_disp` holds the largest disparity at which an obstacle was found, or `obst_valid` is 0 if none was found. Both thresholds are sampled in the cycle of the accepted `frame_start`, and later changes have no effect on that scan.
- R9: `scan_done` is high for exactly one cycle. It is first seen high ROWS*NDISP+3 cycles after the cycle in which `frame_start` is high. `obst_valid` and `obst_disp` change only in that cycle.
- R10: During and just after reset, `obst_valid` and `scan_done` are 0. A frame closed with no pairs reports no obstacle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse that closes the current frame and starts its scan |
| pix_valid | input | 1 | Qualifies `pix_row` and `pix_disp` |
| pix_row | input | $clog2(ROWS) | Image row of the pair |
| pix_disp | input | $clog2(NDISP) | Disparity of the pair |
| bin_thresh | input | CELL_W | Binarization threshold, sampled at frame start |
| hough_thresh | input | $clog2(ROWS+1) | Column vote threshold, sampled at frame start |
| obst_valid | output | 1 | An obstacle was found in the last scanned frame |
| obst_disp | output | $clog2(NDISP) | Disparity of the nearest obstacle |
| scan_done | output | 1 | One-cycle pulse at the end of each scan |

## Verification
The main function is driven with single vertical streaks of repeated hits, and each streak sits just above or just at one of the thresholds. This separates the strictly-greater rule from greater-or-equal, for both binarization and the column vote. Streaks placed in disparity columns 9 and 10 locate the background edge. Two streaks of different disparity and height show whether the nearest column wins only when it really passes. A reused bank with sub-threshold hits exposes any missed clear, because stale counts would push the cells over the threshold. Long bursts on one cell, streams of out-of-range disparities that would otherwise alias into a foreground column, and threshold changes made during a scan test saturation, the dropping of invalid pairs and threshold sampling.

// File: rtl/vdo_pkg.sv
package vdo_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_RUN   = 2'd1,
    SC_DRAIN = 2'd2,
    SC_PICK  = 2'd3
  } scan_st_e;
endpackage

// File: rtl/vdo_hist_ram.sv
module vdo_hist_ram #(
  parameter int DEPTH = 1280,
  parameter int AW    = 11,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first behaviour: a same-cycle write is not visible here
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vdo_accum.sv
module vdo_accum #(
  parameter int ROWS   = 32,
  parameter int NDISP  = 40,
  parameter int CELL_W = 8,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int DISP_W = $clog2(NDISP),
  localparam int AW     = $clog2(ROWS * NDISP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic [ROW_W-1:0]  pix_row,
  input  logic [DISP_W-1:0] pix_disp,
  input  logic              acc_bank,
  output logic [AW-1:0]     rd_addr,
  input  logic [CELL_W-1:0] rdata,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [AW-1:0]     wr_addr,
  output logic [CELL_W-1:0] wr_data
);
  localparam logic [CELL_W-1:0] CELL_MAX = '1;

  logic row_ok, disp_ok, in_ok;

  if (ROWS == (1 << ROW_W)) begin : g_row_full
    assign row_ok = 1'b1;
  end else begin : g_row_part
    assign row_ok = ({1'b0, pix_row} < (ROW_W + 1)'(ROWS));
  end

  if (NDISP == (1 << DISP_W)) begin : g_disp_full
    assign disp_ok = 1'b1;
  end else begin : g_disp_part
    assign disp_ok = ({1'b0, pix_disp} < (DISP_W + 1)'(NDISP));
  end

  assign in_ok   = pix_valid && row_ok && disp_ok;
  assign rd_addr = AW'(pix_row) * AW'(NDISP) + AW'(pix_disp);

  // stage 1: read data returns; stage 2: last written value for forwarding
  logic              s1_valid, s1_bank;
  logic [AW-1:0]     s1_addr;
  logic              s2_valid, s2_bank;
  logic [AW-1:0]     s2_addr;
  logic [CELL_W-1:0] s2_data;
  logic [CELL_W-1:0] base, bumped;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_bank  <= 1'b0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= in_ok;
      s1_bank  <= acc_bank;
      s1_addr  <= rd_addr;
    end
  end

  always_comb begin
    if (s2_valid && s2_bank == s1_bank && s2_addr == s1_addr) base = s2_data;
    else base = rdata;
    bumped = (base == CELL_MAX) ? base : base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_bank  <= 1'b0;
      s2_addr  <= '0;
      s2_data  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_bank  <= s1_bank;
      s2_addr  <= s1_addr;
      s2_data  <= bumped;
    end
  end

  assign wr_en   = s1_valid;
  assign wr_bank = s1_bank;
  assign wr_addr = s1_addr;
  assign wr_data = bumped;
endmodule

// File: rtl/vdo_scan.sv
module vdo_scan
  import vdo_pkg::*;
#(
  parameter int ROWS    = 32,
  parameter int NDISP   = 40,
  parameter int CELL_W  = 8,
  parameter int BG_DISP = 10,
  localparam int DISP_W = $clog2(NDISP),
  localparam int AW     = $clog2(ROWS * NDISP),
  localparam int DEPTH  = ROWS * NDISP,
  localparam int HC_W   = $clog2(ROWS + 1),
  localparam int NINT   = NDISP - BG_DISP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_bank,
  input  logic [CELL_W-1:0] bin_thresh,
  input  logic [HC_W-1:0]   hough_thresh,
  output logic              busy,
  output logic              scan_bank,
  output logic [AW-1:0]     rd_addr,
  input  logic [CELL_W-1:0] rdata,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              obst_valid,
  output logic [DISP_W-1:0] obst_disp,
  output logic              scan_done
);
  scan_st_e          st;
  logic [AW-1:0]     cnt;
  logic [DISP_W-1:0] dcol;
  logic              rv1;
  logic [DISP_W-1:0] d1;
  logic [AW-1:0]     a1;
  logic [CELL_W-1:0] bin_q;
  logic [HC_W-1:0]   hough_q;
  logic              clr_cols;
  logic              pass;

  assign busy = (st != SC_IDLE);
  assign clr_cols = start && (st == SC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SC_IDLE;
      cnt       <= '0;
      dcol      <= '0;
      scan_bank <= 1'b0;
      bin_q     <= '0;
      hough_q   <= '0;
    end else begin
      case (st)
        SC_IDLE: if (start) begin
          st        <= SC_RUN;
          cnt       <= '0;
          dcol      <= '0;
          scan_bank <= start_bank;
          bin_q     <= bin_thresh;
          hough_q   <= hough_thresh;
        end
        SC_RUN: begin
          cnt  <= cnt + 1'b1;
          dcol <= (dcol == DISP_W'(NDISP - 1)) ? '0 : dcol + 1'b1;
          if (cnt == AW'(DEPTH - 1)) st <= SC_DRAIN;
        end
        SC_DRAIN: st <= SC_PICK;
        default:  st <= SC_IDLE;
      endcase
    end
  end

  // one-cycle pipeline matching the RAM read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      rv1 <= 1'b0;
      d1  <= '0;
      a1  <= '0;
    end else begin
      rv1 <= (st == SC_RUN);
      d1  <= dcol;
      a1  <= cnt;
    end
  end

  assign rd_addr = cnt;
  assign wr_en   = rv1;
  assign wr_addr = a1;
  assign pass    = rv1 && (d1 >= DISP_W'(BG_DISP)) && (rdata > bin_q);

  logic [HC_W-1:0] colcnt [NINT];

  for (genvar i = 0; i < NINT; i++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst || clr_cols) colcnt[i] <= '0;
      else if (pass && d1 == DISP_W'(BG_DISP + i)) colcnt[i] <= colcnt[i] + 1'b1;
    end
  end

  logic              found;
  logic [DISP_W-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NINT; i++) begin
      if (colcnt[i] > hough_q) begin
        found = 1'b1;
        best  = DISP_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obst_valid <= 1'b0;
      obst_disp  <= '0;
      scan_done  <= 1'b0;
    end else begin
      scan_done <= (st == SC_PICK);
      if (st == SC_PICK) begin
        obst_valid <= found;
        obst_disp  <= found ? best + DISP_W'(BG_DISP) : '0;
      end
    end
  end
endmodule

// File: rtl/vdo_detector.sv
module vdo_detector #(
  parameter int ROWS    = 32,
  parameter int NDISP   = 40,
  parameter int CELL_W  = 8,
  parameter int BG_DISP = 10,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int DISP_W = $clog2(NDISP),
  localparam int HC_W   = $clog2(ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [ROW_W-1:0]  pix_row,
  input  logic [DISP_W-1:0] pix_disp,
  input  logic [CELL_W-1:0] bin_thresh,
  input  logic [HC_W-1:0]   hough_thresh,
  output logic              obst_valid,
  output logic [DISP_W-1:0] obst_disp,
  output logic              scan_done
);
  localparam int DEPTH = ROWS * NDISP;
  localparam int AW    = $clog2(DEPTH);

  logic              acc_bank;
  logic              scan_busy, scan_bank;
  logic              start_ok;
  logic [AW-1:0]     acc_rd_addr, acc_wr_addr;
  logic              acc_wr_en, acc_wr_bank;
  logic [CELL_W-1:0] acc_wr_data;
  logic [AW-1:0]     scn_rd_addr, scn_wr_addr;
  logic              scn_wr_en;
  logic [CELL_W-1:0] bank_rdata [2];

  assign start_ok = frame_start && !scan_busy;

  always_ff @(posedge clk) begin
    if (rst) acc_bank <= 1'b0;
    else if (start_ok) acc_bank <= ~acc_bank;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              we;
    logic [AW-1:0]     waddr, raddr;
    logic [CELL_W-1:0] wdata;

    always_comb begin
      raddr = (acc_bank == 1'(b)) ? acc_rd_addr : scn_rd_addr;
      if (acc_wr_en && acc_wr_bank == 1'(b)) begin
        we = 1'b1; waddr = acc_wr_addr; wdata = acc_wr_data;
      end else begin
        we = scn_wr_en && (scan_bank == 1'(b)); waddr = scn_wr_addr; wdata = '0;
      end
    end

    vdo_hist_ram #(.DEPTH(DEPTH), .AW(AW), .DW(CELL_W)) u_ram (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (bank_rdata[b])
    );
  end

  vdo_accum #(.ROWS(ROWS), .NDISP(NDISP), .CELL_W(CELL_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_row   (pix_row),
    .pix_disp  (pix_disp),
    .acc_bank  (acc_bank),
    .rd_addr   (acc_rd_addr),
    .rdata     (bank_rdata[acc_wr_bank]),
    .wr_en     (acc_wr_en),
    .wr_bank   (acc_wr_bank),
    .wr_addr   (acc_wr_addr),
    .wr_data   (acc_wr_data)
  );

  vdo_scan #(.ROWS(ROWS), .NDISP(NDISP), .CELL_W(CELL_W), .BG_DISP(BG_DISP)) u_scan (
    .clk          (clk),
    .rst          (rst),
    .start        (frame_start),
    .start_bank   (acc_bank),
    .bin_thresh   (bin_thresh),
    .hough_thresh (hough_thresh),
    .busy         (scan_busy),
    .scan_bank    (scan_bank),
    .rd_addr      (scn_rd_addr),
    .rdata        (bank_rdata[scan_bank]),
    .wr_en        (scn_wr_en),
    .wr_addr      (scn_wr_addr),
    .obst_valid   (obst_valid),
    .obst_disp    (obst_disp),
    .scan_done    (scan_done)
  );
endmodule

// File: rtl/vdo_detector_chk.sv
module vdo_detector_chk #(
  parameter int NDISP   = 40,
  parameter int CELL_W  = 8,
  parameter int BG_DISP = 10,
  parameter int DISP_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              pix_valid,
  input logic [DISP_W-1:0] pix_disp,
  input logic              obst_valid,
  input logic [DISP_W-1:0] obst_disp,
  input logic              scan_done,
  input logic              acc_bank,
  input logic              scan_busy,
  input logic              scan_bank,
  input logic              acc_wr_en,
  input logic              acc_wr_bank,
  input logic [CELL_W-1:0] acc_wr_data,
  input logic              scn_wr_en
);
  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  // R9: results only move together with the done pulse
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !scan_done |-> ($stable(obst_valid) && $stable(obst_disp)));

  // R5: a reported obstacle never lies in the background columns
  assert_disp_range_R5: assert property (@(posedge clk) disable iff (rst)
    obst_valid |-> (obst_disp >= DISP_W'(BG_DISP) && {1'b0, obst_disp} < (DISP_W + 1)'(NDISP)));

  // R3: an increment never wraps a cell to zero
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    acc_wr_en |-> (acc_wr_data != '0));

  // R2: an out-of-range disparity produces no write one cycle later
  assert_ignore_R2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && {1'b0, pix_disp} >= (DISP_W + 1)'(NDISP)) |=> !acc_wr_en);

  // R4: the accumulate and clear paths never write the same bank together
  assert_bank_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(acc_wr_en && scn_wr_en && acc_wr_bank == scan_bank));

  // R4: a frame start during a scan leaves the banks where they were
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_start && scan_busy) |=> $stable(acc_bank));

  // R4: a running scan never works on the bank being accumulated
  assert_scan_other_R4: assert property (@(posedge clk) disable iff (rst)
    scn_wr_en |-> (scan_bank != acc_bank));
endmodule

bind vdo_detector vdo_detector_chk #(
  .NDISP(NDISP), .CELL_W(CELL_W), .BG_DISP(BG_DISP), .DISP_W(DISP_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .pix_valid   (pix_valid),
  .pix_disp    (pix_disp),
  .obst_valid  (obst_valid),
  .obst_disp   (obst_disp),
  .scan_done   (scan_done),
  .acc_bank    (acc_bank),
  .scan_busy   (scan_busy),
  .scan_bank   (scan_bank),
  .acc_wr_en   (acc_wr_en),
  .acc_wr_bank (acc_wr_bank),
  .acc_wr_data (acc_wr_data),
  .scn_wr_en   (scn_wr_en)
);

// File: tb/vdo_detector_bench.sv
`timescale 1ns/1ps
module vdo_detector_bench;
  localparam int ROWS = 32;
  localparam int NDISP = 40;
  localparam int SCAN_LAT = ROWS * NDISP + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic [4:0] pix_row = '0;
  logic [5:0] pix_disp = '0;
  logic [7:0] bin_thresh = '0;
  logic [5:0] hough_thresh = '0;
  logic       obst_valid;
  logic [5:0] obst_disp;
  logic       scan_done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vdo_detector u_vdo_detector (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_row(pix_row), .pix_disp(pix_disp), .bin_thresh(bin_thresh),
    .hough_thresh(hough_thresh), .obst_valid(obst_valid), .obst_disp(obst_disp),
    .scan_done(scan_done)
  );

  typedef struct packed {
    logic [5:0] da; logic [5:0] na; logic [3:0] ha;
    logic [5:0] db; logic [5:0] nb; logic [3:0] hb;
    logic [7:0] bin; logic [5:0] hough;
    logic ev; logic [5:0] ed;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{6'd20, 6'd12, 4'd3, 6'd0,  6'd0, 4'd0, 8'd2, 6'd10, 1'b1, 6'd20},
    '{6'd20, 6'd12, 4'd3, 6'd0,  6'd0, 4'd0, 8'd2, 6'd12, 1'b0, 6'd0},
    '{6'd20, 6'd12, 4'd2, 6'd0,  6'd0, 4'd0, 8'd2, 6'd5,  1'b0, 6'd0},
    '{6'd9,  6'd20, 4'd5, 6'd0,  6'd0, 4'd0, 8'd1, 6'd5,  1'b0, 6'd0},
    '{6'd10, 6'd20, 4'd5, 6'd0,  6'd0, 4'd0, 8'd1, 6'd5,  1'b1, 6'd10},
    '{6'd15, 6'd10, 4'd4, 6'd30, 6'd8, 4'd4, 8'd3, 6'd7,  1'b1, 6'd30},
    '{6'd15, 6'd10, 4'd4, 6'd30, 6'd6, 4'd4, 8'd3, 6'd7,  1'b1, 6'd15},
    '{6'd39, 6'd32, 4'd1, 6'd0,  6'd0, 4'd0, 8'd0, 6'd31, 1'b1, 6'd39}
  };
  localparam string TAG [NVEC] = '{
    "R1 R6 R7", "R7", "R4 R6", "R5", "R5 R7", "R8", "R7 R8", "R1 R7"
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int row, input int disp, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_row   = 5'(row);
      pix_disp  = 6'(disp);
    end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // closes the frame, scrambles thresholds during the scan, checks the result
  task automatic close_frame(input int bin, input int hough, input bit ev,
                             input int ed, input string req);
    int k;
    @(negedge clk);
    frame_start  = 1'b1;
    bin_thresh   = 8'(bin);
    hough_thresh = 6'(hough);
    @(negedge clk);
    frame_start  = 1'b0;
    bin_thresh   = 8'd0;
    hough_thresh = 6'd0;
    k = 1;
    while (!scan_done && k < SCAN_LAT + 20) begin
      @(negedge clk);
      k++;
    end
    check(k == SCAN_LAT, "R9 latency", k, SCAN_LAT);
    check(obst_valid == ev, {req, " obst_valid"}, int'(obst_valid), int'(ev));
    if (ev) check(obst_disp == 6'(ed), {req, " obst_disp"}, int'(obst_disp), ed);
    @(negedge clk);
    check(scan_done == 1'b0, "R9 pulse width", int'(scan_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(obst_valid == 1'b0, "R10 reset obst_valid", int'(obst_valid), 0);
    check(scan_done == 1'b0, "R10 reset scan_done", int'(scan_done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(obst_valid == 1'b0, "R10 after reset", int'(obst_valid), 0);

    // empty frame
    close_frame(0, 0, 1'b0, 0, "R10 empty");

    // table of frames
    for (int v = 0; v < NVEC; v++) begin
      for (int r = 0; r < int'(TBL[v].na); r++) send(r, int'(TBL[v].da), int'(TBL[v].ha));
      for (int r = 0; r < int'(TBL[v].nb); r++) send(r, int'(TBL[v].db), int'(TBL[v].hb));
      close_frame(int'(TBL[v].bin), int'(TBL[v].hough), TBL[v].ev, int'(TBL[v].ed), TAG[v]);
    end

    // R3: 300 hits saturate at 255, which is above 254
    send(0, 25, 300);
    close_frame(254, 0, 1'b1, 25, "R3 saturate");
    // R3 R6: saturated 255 is not strictly above 255
    send(0, 25, 300);
    close_frame(255, 0, 1'b0, 0, "R3 R6 at max");

    // R2: disparity 63 would alias to column 23 of the next row if not dropped
    for (int r = 0; r < 16; r++) send(r, 63, 3);
    close_frame(1, 5, 1'b0, 0, "R2 out of range");

    // R4: frame start during a running scan is ignored
    for (int r = 0; r < 12; r++) send(r, 22, 3);
    @(negedge clk);
    frame_start = 1'b1; bin_thresh = 8'd2; hough_thresh = 6'd10;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (100) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    while (!scan_done) @(negedge clk);
    check(obst_valid == 1'b1 && obst_disp == 6'd22, "R4 scan result", int'(obst_disp), 22);
    @(negedge clk);
    // bank flipped once only: the next frame starts empty and reports nothing
    close_frame(0, 0, 1'b0, 0, "R4 ignored start");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule